// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a single bank of 32 general-purpose pins controlled through a plain register bus: an address, a write strobe, a 32-bit write word and a 32-bit read word. Reads are combinational and writes take effect on the clock edge where the strobe is high. There is no stall and no back-pressure: every access completes in the cycle it is presented. A valid/ready stream interface does not fit this access pattern, so the bus signals stay plain.

The port holds two logical 32-bit control registers: one sets the driven level of each pin and the other sets the direction of each pin. Each of these registers is stored as two 16-bit halves at neighbouring word addresses. Every write carries its own per-bit enable in the upper half of the write word, so software can set or clear any group of pins with a single write and no read-modify-write. The block drives the pin output and output-enable vectors from these registers.

The external pin levels pass through a two-stage synchronizer and can be read back in one 32-bit access. A fixed identifier word lets software recognise the register layout.

Top module: `gpio_mw_port`

## Requirements
- R1: The level register's low half (pins 0..15) is at address 0x00 and its high half (pins 16..31) is at 0x04. The direction register's low half is at 0x08 and its high half is at 0x0C.
- R2: On a write to any half, stored bit n (n = 0..15) takes write-data bit n only when write-data bit n+16 is 1. When bit n+16 is 0, stored bit n keeps its value.
- R3: A read of a half returns its 16 stored bits in read-data bits 15:0, with bits 31:16 reading 0.
- R4: pin_out bit i equals bit i of the level register, with pins 16..31 taken from the high half.
- R5: pin_oe bit i is 1 (pin driven) when direction bit i is 1, and 0 (pin is an input) when it is 0.
- R6: Address 0x78 reads 0x01000C2B. Writes to it change no state.
- R7: Address 0x70 returns all 32 pin levels in one read. A change on pin_in becomes visible there after exactly two rising clock edges.
- R8: After reset, every level bit and every direction bit is 0, so pin_out and pin_oe are 0 and the synchronized pin levels read 0.
- R9: Writes to addresses other than 0x00, 0x04, 0x08 and 0x0C change neither pin_out nor pin_oe. Reads of addresses other than the six listed in R1, R6 and R7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write word: bits 31:16 are the bit enables, bits 15:0 are the new values |
| bus_rdata | output | 32 | Read word for bus_addr (combinational) |
| pin_in | input | 32 | External pin levels (asynchronous) |
| pin_out | output | 32 | Level driven on each pin |
| pin_oe | output | 32 | Output enable for each pin |

## Verification
The masked-write path is exercised in the following order:
- Writes with a full enable mask, which expose the plain data path.
- Writes that enable only a set group or only a clear group of bits. With an accumulated history in the register, these separate a correct per-bit merge from a whole-half overwrite or a mask applied with the wrong sense.
- A write with an all-zero mask, which must change nothing.

Writes that land on the high halves and on the direction register show whether the two address bits select the right storage. Writes to the identifier and to a gap address show whether stray strobes leak into the pin outputs. Reading the pin port one edge and then two edges after an input change pins down the synchronizer depth.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  // Base addresses of the logical registers (byte addresses).
  localparam int unsigned ADR_LEVEL   = 'h00;
  localparam int unsigned ADR_DIR     = 'h08;
  localparam int unsigned ADR_PINS    = 'h70;
  localparam int unsigned ADR_IDENT   = 'h78;
  // Distance between the low and the high half of a register.
  localparam int unsigned HALF_STRIDE = 4;
  // Number of writable logical registers.
  localparam int unsigned NUM_CTRL    = 2;
  // Fixed identifier word.
  localparam logic [31:0] IDENT_WORD  = 32'h0100_0C2B;
endpackage

// File: rtl/gpio_mw_halfreg.sv
module gpio_mw_halfreg #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2*W-1:0] wr_word,
  output logic [W-1:0]   q
);
  logic [W-1:0] en_bits;
  logic [W-1:0] new_bits;

  assign en_bits  = wr_word[2*W-1:W];
  assign new_bits = wr_word[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= (q & ~en_bits) | (new_bits & en_bits);
  end

  // R2: bits whose enable was clear keep their value
  p_unmasked_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~$past(en_bits)) == '0));
  // R2: bits whose enable was set take the written value
  p_masked_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(new_bits)) & $past(en_bits)) == '0));
  // R2: no write, no change
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  // Edges seen since reset, saturating; arms the latency check.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R7: output equals the input seen two edges earlier
  p_two_edge_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port #(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [2*HALF_W-1:0] bus_wdata,
  output logic [2*HALF_W-1:0] bus_rdata,
  input  logic [2*HALF_W-1:0] pin_in,
  output logic [2*HALF_W-1:0] pin_out,
  output logic [2*HALF_W-1:0] pin_oe
);
  import gpio_mw_pkg::*;

  localparam int PINS = 2 * HALF_W;
  localparam int IDX_LEVEL = 0;
  localparam int IDX_DIR   = 1;

  logic [HALF_W-1:0] half_q [NUM_CTRL][2];
  logic [NUM_CTRL*2-1:0] half_hit;
  logic [PINS-1:0] pins_sync;

  // One masked half-register per (logical register, half).
  for (genvar r = 0; r < NUM_CTRL; r++) begin : g_reg
    localparam int unsigned BASE = (r == IDX_LEVEL) ? ADR_LEVEL : ADR_DIR;
    for (genvar h = 0; h < 2; h++) begin : g_half
      assign half_hit[r*2+h] = (bus_addr == ADDR_W'(BASE + h * HALF_STRIDE));
      gpio_mw_halfreg #(.W(HALF_W)) u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && half_hit[r*2+h]),
        .wr_word (bus_wdata),
        .q       (half_q[r][h])
      );
    end
  end

  gpio_mw_sync #(.W(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  assign pin_out = {half_q[IDX_LEVEL][1], half_q[IDX_LEVEL][0]};
  assign pin_oe  = {half_q[IDX_DIR][1],   half_q[IDX_DIR][0]};

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_CTRL * 2; k++) begin
      if (half_hit[k]) bus_rdata = {{HALF_W{1'b0}}, half_q[k/2][k%2]};
    end
    if (bus_addr == ADDR_W'(ADR_PINS))  bus_rdata = pins_sync;
    if (bus_addr == ADDR_W'(ADR_IDENT)) bus_rdata = PINS'(IDENT_WORD);
  end

  // R9: strobes outside the control halves leave the pins alone
  p_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (half_hit == '0)) |=> ($stable(pin_out) && $stable(pin_oe)));
  // R3: half reads never carry data in the upper bits
  p_half_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_hit != '0) |-> (bus_rdata[PINS-1:HALF_W] == '0));
  // R6: identifier is fixed
  p_ident_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(ADR_IDENT)) |-> (bus_rdata == PINS'(IDENT_WORD)));
endmodule

// File: tb/gpio_mw_port_bench.sv
module gpio_mw_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_mw_port u_gpio_mw_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {address, write word, expected 16-bit readback of that address}
  localparam logic [55:0] VEC [8] = '{
    {8'h00, 32'hFFFF_A5A5, 16'hA5A5},
    {8'h00, 32'h00F0_FFFF, 16'hA5F5},
    {8'h00, 32'h0F00_0000, 16'hA0F5},
    {8'h00, 32'h0000_FFFF, 16'hA0F5},
    {8'h04, 32'h8001_FFFF, 16'h8001},
    {8'h04, 32'hFFFF_1234, 16'h1234},
    {8'h08, 32'h0003_0002, 16'h0002},
    {8'h0C, 32'hC000_4000, 16'h4000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check("R8 pin_out", pin_out, 32'h0);
    check("R8 pin_oe", pin_oe, 32'h0);
    bus_read(8'h00, rd); check("R8 level lo", rd, 32'h0);
    bus_read(8'h0C, rd); check("R8 dir hi", rd, 32'h0);
    bus_read(8'h70, rd); check("R8 pins", rd, 32'h0);

    // R1 R2 R3 vector table
    for (int i = 0; i < 8; i++) begin
      bus_write(VEC[i][55:48], VEC[i][47:16]);
      bus_read(VEC[i][55:48], rd);
      check("R2 masked write", rd, {16'h0, VEC[i][15:0]});
    end

    // R4 R5 outputs and R1 half placement
    check("R4 pin_out", pin_out, 32'h1234_A0F5);
    check("R5 pin_oe", pin_oe, 32'h4000_0002);
    bus_read(8'h08, rd); check("R1 dir lo", rd, 32'h0000_0002);
    bus_read(8'h04, rd); check("R3 hi upper zero", rd, 32'h0000_1234);

    // R6 identifier, write ignored
    bus_read(8'h78, rd); check("R6 ident", rd, 32'h0100_0C2B);
    bus_write(8'h78, 32'hFFFF_FFFF);
    bus_read(8'h78, rd); check("R6 ident after write", rd, 32'h0100_0C2B);
    check("R6 pin_out after write", pin_out, 32'h1234_A0F5);
    check("R6 pin_oe after write", pin_oe, 32'h4000_0002);

    // R9 unmapped write and read
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h70, 32'hFFFF_0000);
    check("R9 pin_out", pin_out, 32'h1234_A0F5);
    check("R9 pin_oe", pin_oe, 32'h4000_0002);
    bus_read(8'h10, rd); check("R9 read gap", rd, 32'h0);
    bus_read(8'h74, rd); check("R9 read 0x74", rd, 32'h0);

    // R7 pin sampling latency
    @(negedge clk);
    pin_in = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_read(8'h70, rd); check("R7 after one edge", rd, 32'h0);
    @(negedge clk);
    bus_read(8'h70, rd); check("R7 after two edges", rd, 32'hDEAD_BEEF);

    // R5 direction clear back to input
    bus_write(8'h08, 32'h0002_0000);
    check("R5 pin_oe cleared", pin_oe, 32'h4000_0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule